// File: doc/BRIEF.md
# Programmable Panel Timing Generator

This block produces the timing signals for a flat panel from a pair of free-running counters: a pixel counter that wraps at a programmable last-pixel value, and a line counter that advances on each pixel wrap and wraps at a programmable last-line value. Three outputs are derived from the counters: data enable, horizontal sync and vertical sync. Each output is defined by a rectangular window made of a horizontal start and end plus a vertical start and end.

No output has a polarity bit. To invert a sync output, software swaps the start and end values of its window, and the generator then drives the complementary region. The other controls are a run bit, a test mode that replaces the incoming pixels with a constant colour, and a frame-wrap interrupt pulse. All timing values pass through a shadow set. The shadow set is copied into the active set only at a frame boundary, so reprogramming never tears a frame.

Top module: `panel_timing_gen`

## Requirements
- R1: While running, the pixel counter counts 0, 1, … up to the active last-pixel value and then returns to 0; a count at or above that value wraps. The line counter advances on each pixel wrap and returns to 0 after the active last-line value.
- R2: A horizontal window (start S, end E) covers pixels S ≤ h < E when S < E, covers h ≥ S or h < E when S > E, and covers the whole line when S = E.
- R3: A vertical window (start S, end E) covers lines S ≤ v ≤ E when S ≤ E, and covers lines v < E or v > S when S > E.
- R4: de_o, hsync_o and vsync_o are each high when the counter position is inside both the horizontal and vertical parts of that output's window. All outputs are registered and appear one clock after the counter position they describe.
- R5: Write-port map (cfg_addr): 0 = control (bit0 run, bit1 test pattern, bit2 interrupt enable); 1 = test colour; 2 = last pixel; 3 = last line; 4–7 = data-enable window h-start, h-end, v-start, v-end; 8–11 = hsync window in the same order; 12–15 = vsync window in the same order. Control and colour take effect on the next clock. Addresses 2–15 write a shadow set, which becomes active only on the clock where the running counters leave (last pixel, last line), or on any clock while stopped.
- R6: While the run bit is clear, both counters hold their values and de_o, hsync_o, vsync_o and line_irq_o are low. Setting the run bit again resumes counting from the held position.
- R7: pix_o is the test colour when the test bit is set and pix_i otherwise, in both cases one clock later. A colour of zero gives a black pattern.
- R8: With the run and interrupt-enable bits set, line_irq_o is high for one clock directly after the clock on which the counters sat at (last pixel, last line); otherwise it is low.
- R9: After reset, both counters, all registers and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe of the register port |
| cfg_addr | input | 4 | Register address (R5) |
| cfg_wdata | input | PW | Write data; timing registers use the low TW bits |
| pix_i | input | PW | Incoming pixel |
| de_o | output | 1 | Data enable |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| line_irq_o | output | 1 | Frame-wrap interrupt pulse |
| pix_o | output | PW | Outgoing pixel or test colour |

## Verification
The bench keeps the default widths (TW = 12, PW = 24) and programs a tiny raster of 10 pixels by 6 lines, later shrunk to 8 pixels, so each frame lasts only a few dozen clocks. That lets one run cover many frame wraps, shadow commits at frame boundaries, sync windows swapped in the middle of a frame, a stop in the middle of a frame and the resume after it, and the equal-start-and-end full-line case.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_COLOR = 4'd1;
  localparam int                TIM_BASE = 2;

  // timing set: last pixel, last line, then 3 windows of 4 fields
  localparam int N_WIN     = 3;
  localparam int WIN_FIELDS = 4;
  localparam int N_TIM     = 2 + N_WIN * WIN_FIELDS;
  localparam int T_HMAX    = 0;
  localparam int T_VMAX    = 1;
  localparam int T_WIN0    = 2;

  localparam int W_DE = 0;
  localparam int W_HS = 1;
  localparam int W_VS = 2;

  localparam int CTRL_W    = 3;
  localparam int CTRL_RUN  = 0;
  localparam int CTRL_TEST = 1;
  localparam int CTRL_IRQ  = 2;
endpackage

// File: rtl/ptg_cfg.sv
module ptg_cfg
  import ptg_pkg::*;
#(
  parameter int TW = 12,
  parameter int PW = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [PW-1:0]       wr_data,
  input  logic                commit,
  output logic [CTRL_W-1:0]   ctrl,
  output logic [PW-1:0]       color,
  output logic [TW-1:0]       act [N_TIM]
);
  logic [CTRL_W-1:0] ctrl_d;
  logic [PW-1:0]     color_d;
  logic [TW-1:0]     shd_q [N_TIM];
  logic [TW-1:0]     shd_d [N_TIM];
  logic [TW-1:0]     act_d [N_TIM];

  always_comb begin
    ctrl_d  = ctrl;
    color_d = color;
    shd_d   = shd_q;
    act_d   = act;
    if (commit) act_d = shd_q;
    if (wr_en) begin
      if (wr_addr == A_CTRL)  ctrl_d  = wr_data[CTRL_W-1:0];
      if (wr_addr == A_COLOR) color_d = wr_data;
      for (int i = 0; i < N_TIM; i++) begin
        if (wr_addr == ADDR_W'(i + TIM_BASE)) shd_d[i] = wr_data[TW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      color <= '0;
      for (int i = 0; i < N_TIM; i++) begin
        shd_q[i] <= '0;
        act[i]   <= '0;
      end
    end else begin
      ctrl  <= ctrl_d;
      color <= color_d;
      shd_q <= shd_d;
      act   <= act_d;
    end
  end
endmodule

// File: rtl/ptg_count.sv
module ptg_count #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] hmax,
  input  logic [TW-1:0] vmax,
  output logic [TW-1:0] h,
  output logic [TW-1:0] v,
  output logic          at_end
);
  logic          h_wrap;
  logic [TW-1:0] h_d;
  logic [TW-1:0] v_d;

  assign h_wrap = (h >= hmax);
  assign at_end = h_wrap && (v >= vmax);

  always_comb begin
    h_d = h;
    v_d = v;
    if (run) begin
      if (h_wrap) begin
        h_d = '0;
        v_d = (v >= vmax) ? '0 : v + TW'(1);
      end else begin
        h_d = h + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h <= '0;
      v <= '0;
    end else if (run) begin
      h <= h_d;
      v <= v_d;
    end
  end
endmodule

// File: rtl/ptg_window.sv
module ptg_window #(
  parameter int TW = 12
) (
  input  logic [TW-1:0] h,
  input  logic [TW-1:0] v,
  input  logic [TW-1:0] hs,
  input  logic [TW-1:0] he,
  input  logic [TW-1:0] vs,
  input  logic [TW-1:0] ve,
  output logic          hit
);
  logic h_ok;
  logic v_ok;

  always_comb begin
    if (hs < he)      h_ok = (h >= hs) && (h < he);
    else if (hs > he) h_ok = (h >= hs) || (h < he);
    else              h_ok = 1'b1;
    if (vs <= ve)     v_ok = (v >= vs) && (v <= ve);
    else              v_ok = (v > vs) || (v < ve);
    hit = h_ok && v_ok;
  end
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
  import ptg_pkg::*;
#(
  parameter int TW = 12,
  parameter int PW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [PW-1:0]     cfg_wdata,
  input  logic [PW-1:0]     pix_i,
  output logic              de_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              line_irq_o,
  output logic [PW-1:0]     pix_o
);
  logic [CTRL_W-1:0] ctrl;
  logic [PW-1:0]     color;
  logic [TW-1:0]     act [N_TIM];
  logic              run;
  logic              test;
  logic              irq_en;
  logic              commit;
  logic              at_end;
  logic [TW-1:0]     cnt_h;
  logic [TW-1:0]     cnt_v;
  logic [N_WIN-1:0]  hit;

  logic              de_d, hs_d, vs_d, irq_d;
  logic [PW-1:0]     pix_d;

  assign run    = ctrl[CTRL_RUN];
  assign test   = ctrl[CTRL_TEST];
  assign irq_en = ctrl[CTRL_IRQ];
  assign commit = !run || at_end;

  ptg_cfg #(.TW(TW), .PW(PW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .commit(commit), .ctrl(ctrl), .color(color), .act(act)
  );

  ptg_count #(.TW(TW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .hmax(act[T_HMAX]), .vmax(act[T_VMAX]),
    .h(cnt_h), .v(cnt_v), .at_end(at_end)
  );

  for (genvar k = 0; k < N_WIN; k++) begin : g_win
    ptg_window #(.TW(TW)) u_win (
      .h(cnt_h), .v(cnt_v),
      .hs(act[T_WIN0 + WIN_FIELDS*k + 0]),
      .he(act[T_WIN0 + WIN_FIELDS*k + 1]),
      .vs(act[T_WIN0 + WIN_FIELDS*k + 2]),
      .ve(act[T_WIN0 + WIN_FIELDS*k + 3]),
      .hit(hit[k])
    );
  end

  always_comb begin
    de_d  = run && hit[W_DE];
    hs_d  = run && hit[W_HS];
    vs_d  = run && hit[W_VS];
    irq_d = run && irq_en && at_end;
    pix_d = test ? color : pix_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_o       <= 1'b0;
      hsync_o    <= 1'b0;
      vsync_o    <= 1'b0;
      line_irq_o <= 1'b0;
      pix_o      <= '0;
    end else begin
      de_o       <= de_d;
      hsync_o    <= hs_d;
      vsync_o    <= vs_d;
      line_irq_o <= irq_d;
      pix_o      <= pix_d;
    end
  end
endmodule

// File: rtl/ptg_checker.sv
module ptg_checker #(
  parameter int TW = 12,
  parameter int PW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          test,
  input logic          commit,
  input logic [TW-1:0] h,
  input logic [TW-1:0] v,
  input logic [TW-1:0] hmax,
  input logic [TW-1:0] vmax,
  input logic [PW-1:0] color,
  input logic          de_o,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic          line_irq_o,
  input logic [PW-1:0] pix_o
);
  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run && (h >= hmax) |=> h == '0);

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run && (h < hmax) |=> h == $past(h) + TW'(1));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(h) && $stable(v));

  assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !de_o && !hsync_o && !vsync_o && !line_irq_o);

  assert_shadow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(hmax) && $stable(vmax));

  assert_pattern_R7: assert property (@(posedge clk) disable iff (!rst_n)
    test |=> pix_o == $past(color));
endmodule

bind panel_timing_gen ptg_checker #(.TW(TW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .test(test), .commit(commit),
  .h(cnt_h), .v(cnt_v), .hmax(act[0]), .vmax(act[1]), .color(color),
  .de_o(de_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
  .line_irq_o(line_irq_o), .pix_o(pix_o)
);

// File: tb/panel_timing_gen_tb.sv
`timescale 1ns/1ps
module panel_timing_gen_tb;
  localparam int TW = 12;
  localparam int PW = 24;
  localparam int NT = 14;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [3:0]    cfg_addr;
  logic [PW-1:0] cfg_wdata;
  logic [PW-1:0] pix_i;
  logic          de_o, hsync_o, vsync_o, line_irq_o;
  logic [PW-1:0] pix_o;

  always #2.5 clk = ~clk;

  panel_timing_gen #(.TW(TW), .PW(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_i(pix_i), .de_o(de_o), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .line_irq_o(line_irq_o), .pix_o(pix_o)
  );

  typedef struct packed {
    logic          de;
    logic          hs;
    logic          vs;
    logic          irq;
    logic [PW-1:0] pix;
  } exp_t;

  exp_t  q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  string tag = "R9";
  bit    done = 1'b0;

  // reference state built from the requirements
  int mh, mv;
  int shd [NT];
  int act [NT];
  bit m_run, m_test, m_irq;
  int m_color;

  function automatic bit hwin(int h, int s, int e);
    if (s < e) return (h >= s) && (h < e);
    if (s > e) return (h >= s) || (h < e);
    return 1'b1;
  endfunction

  function automatic bit vwin(int v, int s, int e);
    if (s <= e) return (v >= s) && (v <= e);
    return (v > s) || (v < e);
  endfunction

  function automatic bit win(int k);
    return hwin(mh, act[2+4*k], act[3+4*k]) && vwin(mv, act[4+4*k], act[5+4*k]);
  endfunction

  // driver side: predicts each clock's outputs and queues them
  always @(posedge clk) begin
    if (!rst_n) begin
      mh = 0; mv = 0; m_run = 0; m_test = 0; m_irq = 0; m_color = 0;
      for (int i = 0; i < NT; i++) begin shd[i] = 0; act[i] = 0; end
    end else begin
      exp_t e;
      bit   last, commit;
      last   = (mh >= act[0]) && (mv >= act[1]);
      e.de   = m_run && win(0);
      e.hs   = m_run && win(1);
      e.vs   = m_run && win(2);
      e.irq  = m_run && m_irq && last;
      e.pix  = m_test ? PW'(m_color) : pix_i;
      q.push_back(e);
      commit = !m_run || last;
      if (m_run) begin
        if (mh >= act[0]) begin
          mh = 0;
          mv = (mv >= act[1]) ? 0 : mv + 1;
        end else mh = mh + 1;
      end
      if (commit) for (int i = 0; i < NT; i++) act[i] = shd[i];
      if (cfg_we) begin
        if (cfg_addr == 4'd0) begin
          m_run = cfg_wdata[0]; m_test = cfg_wdata[1]; m_irq = cfg_wdata[2];
        end else if (cfg_addr == 4'd1) m_color = int'(cfg_wdata);
        else shd[int'(cfg_addr) - 2] = int'(cfg_wdata[TW-1:0]);
      end
    end
  end

  // monitor side: compares away from the active edge
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      exp_t got;
      e   = q.pop_front();
      got = {de_o, hsync_o, vsync_o, line_irq_o, pix_o};
      n_chk++;
      if (got !== e) begin
        n_bad++;
        $display("FAIL %s de/hs/vs/irq/pix actual %b%b%b%b/%h expected %b%b%b%b/%h",
                 tag, got.de, got.hs, got.vs, got.irq, got.pix,
                 e.de, e.hs, e.vs, e.irq, e.pix);
      end
    end
  end

  always @(negedge clk) if (rst_n) pix_i <= pix_i + 24'h010203;

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = 4'(a);
    cfg_wdata = PW'(d);
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired, actual hung, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; pix_i = 24'h000001;
    repeat (3) @(negedge clk);
    // R9: reset state
    n_chk++;
    if ({de_o, hsync_o, vsync_o, line_irq_o, pix_o} !== '0) begin
      n_bad++;
      $display("FAIL R9 reset outputs actual %b%b%b%b/%h expected 0000/000000",
               de_o, hsync_o, vsync_o, line_irq_o, pix_o);
    end
    rst_n = 1'b1;

    tag = "R5";  // program while stopped: commit every clock
    wr(2, 9);  wr(3, 5);
    wr(4, 3);  wr(5, 8);  wr(6, 1); wr(7, 4);
    wr(8, 0);  wr(9, 2);  wr(10, 0); wr(11, 5);
    wr(12, 0); wr(13, 0); wr(14, 0); wr(15, 1);

    tag = "R1"; // counters, windows R2 R3 R4
    wr(0, 1);
    idle(130);

    tag = "R7"; // black pattern then colour
    wr(1, 0); wr(0, 3); idle(20);
    wr(1, 24'h123456); idle(10);
    wr(0, 1); idle(10);

    tag = "R8"; // frame interrupt
    wr(0, 5); idle(130);

    tag = "R5"; // swap sync windows and shrink line mid-frame
    wr(8, 2); wr(9, 0); wr(14, 1); wr(15, 0); wr(2, 7);
    idle(150);

    tag = "R6"; // stop mid-frame, resume
    wr(0, 0); idle(15);
    wr(0, 5); idle(80);

    tag = "R2"; // equal start and end gives a full line
    wr(4, 4); wr(5, 4); idle(120);

    tag = "R3"; // swapped vertical de window
    wr(6, 4); wr(7, 1); idle(120);

    idle(3);
    finish_run();
  end
endmodule